// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits between a processor core, its interrupt request pins and the bus interface. It decides when an external interrupt is taken and which vector number goes with it. There are two request sources. One is a level-sensitive maskable request, honoured only while the core's interrupt-enable flag is set. The other is an edge-triggered non-maskable request. The block waits for the instruction-boundary strobe from the core, so an interrupt is only taken once the running instruction has completed.

A maskable interrupt makes the block run a back-to-back pair of interrupt-acknowledge bus cycles. The bus is held locked for the whole pair, and the vector number is captured from the data returned by the last cycle. A non-maskable interrupt skips the bus entirely and uses a fixed vector. When the vector is known, the block gives the core a one-cycle take pulse that carries the vector number and a flag marking the non-maskable case. After a non-maskable interrupt is taken, the block blocks further ones until the core signals that the handler has ended.

Top module: `intack_seq`

## Requirements
- R1: A maskable request present at a boundary starts an acknowledge sequence only if `ien_i` is 1 in that cycle. With `ien_i` at 0 there is no bus activity and no take pulse.
- R2: A request is acted on only in a cycle where `boundary_i` is 1 and the block is idle. A boundary is ignored while an acknowledge sequence is running and in the cycle where `take_o` is 1.
- R3: An accepted maskable request raises `ack_req_o` in the cycle after the boundary. The signal stays at 1 across exactly `ACK_CNT` acknowledge cycles, and each cycle ends when `ack_done_i` is 1. A new cycle starts immediately after each completion, even when `ack_done_i` stays at 1 continuously.
- R4: `ack_lock_o` is 1 from the first cycle of the sequence up to and including the cycle in which the last acknowledge completes. It is 0 in the following cycle and whenever the block is idle.
- R5: The maskable vector is the value of `ack_data_i` in the cycle where the last acknowledge completes. Data returned by earlier acknowledge cycles has no effect on the vector.
- R6: `take_o` is a one-cycle pulse. For a maskable interrupt it comes in the cycle after the last acknowledge completes, with `take_nmi_o` at 0. For a non-maskable interrupt it comes in the cycle after the boundary, with `take_nmi_o` at 1.
- R7: A non-maskable interrupt is taken regardless of `ien_i`, causes no bus cycle, and delivers vector `NMI_VEC` (default 2).
- R8: A rising edge on `nmi_i` is latched. A pulse of a single cycle that ends before any boundary is still taken at a later boundary.
- R9: When a non-maskable interrupt is pending and a maskable request is valid at the same boundary, the non-maskable one is taken and no acknowledge cycle starts.
- R10: After a non-maskable interrupt is taken, new `nmi_i` edges stay pending and are not taken until `eoh_i` has been 1 for a cycle. After that, the pending one is taken at the next boundary.
- R11: While `rst_ni` is 0, all outputs are 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_i | input | 1 | Maskable interrupt request, level |
| nmi_i | input | 1 | Non-maskable interrupt request, rising edge |
| ien_i | input | 1 | Interrupt-enable flag from the core |
| boundary_i | input | 1 | Instruction boundary strobe |
| eoh_i | input | 1 | End of non-maskable handler |
| ack_req_o | output | 1 | Acknowledge bus cycle requested |
| ack_lock_o | output | 1 | Bus lock across the acknowledge sequence |
| ack_done_i | input | 1 | Current acknowledge cycle completes |
| ack_data_i | input | VEC_W | Data returned by the acknowledge cycle |
| take_o | output | 1 | Take-interrupt pulse to the core |
| take_nmi_o | output | 1 | Pulse is for a non-maskable interrupt |
| take_vec_o | output | VEC_W | Vector number |

## Verification
The bench uses the default parameters: an 8-bit vector, a fixed non-maskable vector of 2, and two acknowledge cycles per sequence. With these values it can check that the first cycle's data is discarded, both when completions are spaced apart and when `ack_done_i` is held high. A behavioural model is compared against the outputs every clock. On top of that, targeted checks cover enable masking, boundary gating, priority at a shared boundary, and non-maskable edges that stay blocked until the handler ends.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/intack_nmi_trk.sv
module intack_nmi_trk (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic eoh_i,
  input  logic take_nmi_i,
  output logic ready_o
);
  logic nmi_q, pend_q, busy_q;
  logic nmi_rise;

  assign nmi_rise = nmi_i & ~nmi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q  <= 1'b0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      // an edge arriving while the pending one is taken stays latched
      pend_q <= nmi_rise | (pend_q & ~take_nmi_i);
      busy_q <= take_nmi_i | (busy_q & ~eoh_i);
    end
  end

  assign ready_o = pend_q & ~busy_q;
endmodule

// File: rtl/intack_arb.sv
module intack_arb (
  input  logic boundary_i,
  input  logic idle_i,
  input  logic take_i,
  input  logic nmi_ready_i,
  input  logic mreq_i,
  input  logic ien_i,
  output logic go_nmi_o,
  output logic go_mask_o
);
  logic window;

  assign window    = boundary_i & idle_i & ~take_i;
  assign go_nmi_o  = window & nmi_ready_i;
  assign go_mask_o = window & ~nmi_ready_i & mreq_i & ien_i;
endmodule

// File: rtl/intack_ack_fsm.sv
module intack_ack_fsm
  import intack_pkg::*;
#(
  parameter int ACK_CNT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_done_i,
  output logic active_o,
  output logic fin_o
);
  localparam int CW = $clog2(ACK_CNT + 1);

  seq_state_e    state_q;
  logic [CW-1:0] idx_q;
  logic          last;

  assign last     = (idx_q == CW'(ACK_CNT - 1));
  assign active_o = (state_q == ST_ACK);
  assign fin_o    = active_o & ack_done_i & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_ACK;
      idx_q   <= '0;
    end else if (active_o && ack_done_i) begin
      if (last) begin
        state_q <= ST_IDLE;
        idx_q   <= '0;
      end else begin
        idx_q <= idx_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq #(
  parameter int                VEC_W   = 8,
  parameter int                ACK_CNT = 2,
  parameter logic [VEC_W-1:0]  NMI_VEC = VEC_W'(2)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mreq_i,
  input  logic             nmi_i,
  input  logic             ien_i,
  input  logic             boundary_i,
  input  logic             eoh_i,
  output logic             ack_req_o,
  output logic             ack_lock_o,
  input  logic             ack_done_i,
  input  logic [VEC_W-1:0] ack_data_i,
  output logic             take_o,
  output logic             take_nmi_o,
  output logic [VEC_W-1:0] take_vec_o
);
  logic nmi_ready, go_nmi, go_mask, active, fin;
  logic take_q, take_nmi_q;
  logic [VEC_W-1:0] vec_q;

  intack_nmi_trk u_nmi (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .nmi_i      (nmi_i),
    .eoh_i      (eoh_i),
    .take_nmi_i (go_nmi),
    .ready_o    (nmi_ready)
  );

  intack_arb u_arb (
    .boundary_i  (boundary_i),
    .idle_i      (~active),
    .take_i      (take_q),
    .nmi_ready_i (nmi_ready),
    .mreq_i      (mreq_i),
    .ien_i       (ien_i),
    .go_nmi_o    (go_nmi),
    .go_mask_o   (go_mask)
  );

  intack_ack_fsm #(.ACK_CNT(ACK_CNT)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (go_mask),
    .ack_done_i (ack_done_i),
    .active_o   (active),
    .fin_o      (fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q     <= 1'b0;
      take_nmi_q <= 1'b0;
      vec_q      <= '0;
    end else begin
      take_q     <= go_nmi | fin;
      take_nmi_q <= go_nmi;
      if (go_nmi)   vec_q <= NMI_VEC;
      else if (fin) vec_q <= ack_data_i;
      else          vec_q <= '0;
    end
  end

  assign ack_req_o  = active;
  assign ack_lock_o = active;
  assign take_o     = take_q;
  assign take_nmi_o = take_nmi_q;
  assign take_vec_o = vec_q;
endmodule

// File: rtl/intack_seq_chk.sv
module intack_seq_chk #(
  parameter int               VEC_W   = 8,
  parameter logic [VEC_W-1:0] NMI_VEC = VEC_W'(2)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ien_i,
  input logic             boundary_i,
  input logic             ack_req_o,
  input logic             ack_lock_o,
  input logic [VEC_W-1:0] ack_data_i,
  input logic             take_o,
  input logic             take_nmi_o,
  input logic [VEC_W-1:0] take_vec_o
);
  AST_ACK_NEEDS_IEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_req_o) |-> $past(ien_i) && $past(boundary_i)); // R1
  AST_TAKE_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !ack_lock_o); // R4
  AST_LOCK_END_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ack_lock_o) |-> take_o && !take_nmi_o); // R4
  AST_VEC_FROM_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !take_nmi_o) |-> take_vec_o == $past(ack_data_i)); // R5
  AST_TAKE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !take_o); // R6
  AST_NMI_FIXED_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_nmi_o) |-> take_vec_o == NMI_VEC); // R7
  AST_NMI_NO_BUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && take_nmi_o) |-> !$past(ack_req_o)); // R7
endmodule

bind intack_seq intack_seq_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ien_i      (ien_i),
  .boundary_i (boundary_i),
  .ack_req_o  (ack_req_o),
  .ack_lock_o (ack_lock_o),
  .ack_data_i (ack_data_i),
  .take_o     (take_o),
  .take_nmi_o (take_nmi_o),
  .take_vec_o (take_vec_o)
);

// File: tb/sim_intack_seq.sv
module sim_intack_seq;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mreq_i = 0, nmi_i = 0, ien_i = 0, boundary_i = 0, eoh_i = 0, ack_done_i = 0;
  logic [7:0] ack_data_i = '0;
  logic ack_req_o, ack_lock_o, take_o, take_nmi_o;
  logic [7:0] take_vec_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  intack_seq u0 (.*);

  // behavioural reference
  int m_state = 0, m_idx = 0;
  bit m_nq = 0, m_pend = 0, m_busy = 0, m_take = 0, m_tnmi = 0;
  int m_vec = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_state = 0; m_idx = 0; m_nq = 0; m_pend = 0; m_busy = 0;
      m_take = 0; m_tnmi = 0; m_vec = 0;
    end else begin
      bit rise, tk, tn, nstate_ack;
      int nv, nidx, nstate;
      rise = nmi_i && !m_nq;
      tk = 0; tn = 0; nv = 0; nstate = m_state; nidx = m_idx;
      if (m_state == 0 && boundary_i && !m_take) begin
        if (m_pend && !m_busy) begin tk = 1; tn = 1; nv = 2; end
        else if (mreq_i && ien_i) begin nstate = 1; nidx = 0; end
      end else if (m_state == 1 && ack_done_i) begin
        if (m_idx == 1) begin tk = 1; nv = ack_data_i; nstate = 0; nidx = 0; end
        else nidx = m_idx + 1;
      end
      nstate_ack = 0;
      m_pend = rise || (m_pend && !tn);
      m_busy = tn || (m_busy && !eoh_i);
      m_nq = nmi_i;
      m_state = nstate; m_idx = nidx;
      m_take = tk; m_tnmi = tn; m_vec = nv;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && !finished) begin
    chk("R3 model ack_req", int'(ack_req_o), m_state);
    chk("R4 model lock", int'(ack_lock_o), m_state);
    chk("R6 model take", int'(take_o), int'(m_take));
    chk("R7 model take_nmi", int'(take_nmi_o), int'(m_tnmi));
    chk("R5 model vector", int'(take_vec_o), m_vec);
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic bnd;
    boundary_i = 1; tick(); boundary_i = 0;
  endtask

  task automatic summary;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    tick(3);
    chk("R11 reset take", int'(take_o), 0);
    chk("R11 reset req", int'(ack_req_o), 0);
    chk("R11 reset lock", int'(ack_lock_o), 0);
    rst_ni = 1; tick(2);

    // R1: enable clear masks the request
    mreq_i = 1; ien_i = 0; bnd(); tick(3);
    chk("R1 masked no ack", int'(ack_req_o), 0);
    chk("R1 masked no take", int'(take_o), 0);

    // R2: no boundary, no action
    ien_i = 1; tick(4);
    chk("R2 no boundary", int'(ack_req_o), 0);

    // R3 R4 R5: spaced completions, first data discarded
    bnd();
    chk("R3 req after boundary", int'(ack_req_o), 1);
    chk("R4 lock at start", int'(ack_lock_o), 1);
    boundary_i = 1; tick(2); boundary_i = 0; // R2 ignored mid-sequence
    ack_data_i = 8'hAA; ack_done_i = 1; tick(); ack_done_i = 0; ack_data_i = 0;
    chk("R3 second cycle", int'(ack_req_o), 1);
    chk("R4 lock between", int'(ack_lock_o), 1);
    chk("R5 no take yet", int'(take_o), 0);
    tick();
    ack_data_i = 8'h35; ack_done_i = 1; tick(); ack_done_i = 0; ack_data_i = 0;
    chk("R6 take mask", int'(take_o), 1);
    chk("R6 take_nmi low", int'(take_nmi_o), 0);
    chk("R5 vector", int'(take_vec_o), 8'h35);
    chk("R4 lock dropped", int'(ack_lock_o), 0);
    boundary_i = 1; tick(); boundary_i = 0; mreq_i = 0;
    chk("R6 pulse ends", int'(take_o), 0);
    chk("R2 take-cycle boundary ignored", int'(ack_req_o), 0);
    tick(2);

    // R7 R8: short NMI pulse, enable clear
    ien_i = 0; nmi_i = 1; tick(); nmi_i = 0; tick(5);
    chk("R8 held pending", int'(take_o), 0);
    bnd();
    chk("R8 taken later", int'(take_o), 1);
    chk("R7 nmi flag", int'(take_nmi_o), 1);
    chk("R7 nmi vector", int'(take_vec_o), 2);
    chk("R7 no bus", int'(ack_req_o), 0);
    tick();

    // R10: blocked until end of handler
    nmi_i = 1; tick(); nmi_i = 0; tick();
    bnd(); chk("R10 blocked", int'(take_o), 0);
    tick(3); bnd(); chk("R10 still blocked", int'(take_o), 0);
    eoh_i = 1; tick(); eoh_i = 0; tick();
    bnd(); chk("R10 after eoh", int'(take_o), 1);
    chk("R10 nmi flag", int'(take_nmi_o), 1);
    tick(); eoh_i = 1; tick(); eoh_i = 0; tick();

    // R9: NMI beats maskable at the same boundary
    ien_i = 1; mreq_i = 1; nmi_i = 1; tick(); nmi_i = 0; tick();
    bnd();
    chk("R9 nmi wins", int'(take_nmi_o), 1);
    chk("R9 no ack", int'(ack_req_o), 0);
    tick();
    bnd(); chk("R9 mask next", int'(ack_req_o), 1);
    ack_data_i = 8'h11; ack_done_i = 1; tick(); ack_done_i = 0; tick();
    ack_data_i = 8'h7E; ack_done_i = 1; tick(); ack_done_i = 0; ack_data_i = 0;
    chk("R5 vector after nmi", int'(take_vec_o), 8'h7E);
    mreq_i = 0; eoh_i = 1; tick(); eoh_i = 0; tick(2);

    // R3: completion held high, back-to-back
    mreq_i = 1; bnd(); mreq_i = 0;
    ack_done_i = 1; ack_data_i = 8'h01; tick(); ack_data_i = 8'hC3; tick();
    ack_done_i = 0; ack_data_i = 0;
    chk("R3 back-to-back take", int'(take_o), 1);
    chk("R5 back-to-back vector", int'(take_vec_o), 8'hC3);
    tick(3);
    chk("R4 idle unlocked", int'(ack_lock_o), 0);
    summary();
  end
endmodule